// File: doc/BRIEF.md
# Linked-List Bucket Sort Pass Engine

This block carries out a single character pass of a least-significant-character radix sort. The records are not moved. Their order is a singly linked list held as an array of next-record indices. A pass starts at a given record and follows the source links for a given number of records. For each record it fetches one 8-bit key character and files the record into one of 256 buckets. Each bucket is a head/tail pair, and its members are threaded through a destination link array, so the scan takes one record per clock. After the scan, the non-empty buckets are joined in ascending character order. The block then reports the head and tail of the new list and closes the list with an all-ones end marker.

Key bytes and source links are written through a valid/ready load port. The port's ready is low for the whole of a pass. A transfer offered while ready is low is not taken, so the source must hold it until ready returns. The destination links are read back through a registered read port. The character position is chosen with a stride input: record j's character sits at byte address j × stride. Running several passes, and choosing which character each pass uses, is done outside the block. Records are stable within a bucket, so repeated passes from the least significant character to the most significant one sort a multi-byte key.

Top module: `bsp_pass_engine`

## Requirements
- R1: `ld_ready` is high exactly when `busy` is low. A transfer with `ld_valid` and `ld_ready` high and `ld_sel`=0 writes `ld_data` to key byte `ld_addr`. With `ld_sel`=1 it writes `ld_data[REC_AW-1:0]` to source link entry `ld_addr[REC_AW-1:0]`. A transfer offered while `ld_ready` is low has no effect.
- R2: A `start` pulse taken while the block is idle or done clears all 256 bucket flags in that cycle, and `busy` is high from the next cycle. A `start` pulse while `busy` is high is ignored.
- R3: The scan visits `start_rec` first and then follows the source links. It visits exactly `rec_count` records. The key of record j is read at byte address j × `stride`.
- R4: A record that reaches an empty bucket becomes that bucket's head. A record that reaches a non-empty bucket is written into the destination link of the bucket's current tail. In both cases the record then becomes the bucket's tail, so arrival order is kept within a bucket.
- R5: Records with the same character on consecutive scan cycles are linked correctly while the scan keeps one record per cycle.
- R6: Buckets are joined in ascending character order. `new_start` is the head of the lowest non-empty bucket. The tail of each non-empty bucket is linked to the head of the next non-empty bucket.
- R7: `new_end` is the tail of the highest non-empty bucket, and the destination link of that tail holds all ones.
- R8: After reset, `busy` and `done` are low. For `rec_count` N > 0, `busy` stays high until `done` rises exactly N+261 cycles after the accepting clock edge.
- R9: With `rec_count`=0, `done` is high one cycle after the accepting edge, `new_start` and `new_end` are all ones, and no destination link is written.
- R10: `done`, `new_start` and `new_end` hold their values until the next accepted `start`.
- R11: `rd_data` shows destination link entry `rd_addr` one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_valid | input | 1 | Load transfer offered |
| ld_ready | output | 1 | Load transfer can be taken (block not busy) |
| ld_sel | input | 1 | 0 = key byte, 1 = source link |
| ld_addr | input | REC_AW+STRIDE_W | Key byte address or link index (low bits) |
| ld_data | input | CHAR_W | Key byte, or link value in low REC_AW bits |
| start | input | 1 | Begin a pass |
| start_rec | input | REC_AW | First record of the list |
| rec_count | input | REC_AW | Number of records to visit |
| stride | input | STRIDE_W | Byte distance between successive records' keys |
| busy | output | 1 | Pass in progress |
| done | output | 1 | Pass finished, results valid |
| new_start | output | REC_AW | Head of the re-ordered list |
| new_end | output | REC_AW | Tail of the re-ordered list |
| rd_addr | input | REC_AW | Destination link read index |
| rd_data | output | REC_AW | Destination link value, one cycle later |

## Verification
The per-cycle model expects `busy` from the cycle after an accepted start. It expects `done` N+261 edges after that start, or one edge after it for an empty pass, and compares `busy`, `done` and `ld_ready` at every falling edge. List results are read only once `done` is high. Each read sets the address on a falling edge and samples `rd_data` on the next falling edge, after the single registered stage. An ignored load is proven by rerunning a pass and observing that the list comes out unchanged.

// File: rtl/bsp_pkg.sv
package bsp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SCAN,
    ST_DRAIN,
    ST_CHAIN,
    ST_CTAIL,
    ST_DONE
  } bsp_state_e;
endpackage

// File: rtl/bsp_ram.sv
module bsp_ram #(
  parameter int AW = 6,
  parameter int DW = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  // read-during-write returns the old word; the scan bypass relies on it
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/bsp_buckets.sv
module bsp_buckets #(
  parameter int CHAR_W = 8,
  parameter int REC_AW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              upd,
  input  logic [CHAR_W-1:0] upd_key,
  input  logic [REC_AW-1:0] upd_rec,
  output logic              hit,
  input  logic [CHAR_W-1:0] t_raddr,
  output logic [REC_AW-1:0] t_rdata,
  input  logic [CHAR_W-1:0] c_raddr,
  output logic [REC_AW-1:0] c_head,
  output logic              c_flag
);
  localparam int NBKT = 1 << CHAR_W;

  logic [NBKT-1:0] flags_q;

  assign hit = flags_q[upd_key];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      c_flag  <= 1'b0;
    end else begin
      if (clr)      flags_q <= '0;
      else if (upd) flags_q[upd_key] <= 1'b1;
      c_flag <= flags_q[c_raddr];
    end
  end

  bsp_ram #(.AW(CHAR_W), .DW(REC_AW)) u_head (
    .clk(clk), .we(upd && !hit), .waddr(upd_key), .wdata(upd_rec),
    .raddr(c_raddr), .rdata(c_head)
  );

  bsp_ram #(.AW(CHAR_W), .DW(REC_AW)) u_tail (
    .clk(clk), .we(upd), .waddr(upd_key), .wdata(upd_rec),
    .raddr(t_raddr), .rdata(t_rdata)
  );

  // R2: a taken start leaves no bucket marked from the previous pass
  assert_flags_cleared_R2: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (flags_q == '0));

  // R4: the first arrival in an empty bucket marks it occupied
  assert_first_marks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !hit && !clr) |=> flags_q[$past(upd_key)]);
endmodule

// File: rtl/bsp_scan.sv
module bsp_scan #(
  parameter int CHAR_W = 8,
  parameter int REC_AW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic [REC_AW-1:0] issue_rec,
  input  logic [CHAR_W-1:0] key_rdata,
  output logic [CHAR_W-1:0] tail_raddr,
  input  logic [REC_AW-1:0] tail_rdata,
  input  logic              hit,
  output logic              upd,
  output logic [CHAR_W-1:0] upd_key,
  output logic [REC_AW-1:0] upd_rec,
  output logic              dst_we,
  output logic [REC_AW-1:0] dst_waddr,
  output logic [REC_AW-1:0] dst_wdata,
  output logic              pipe_busy
);
  // stage 1: key byte returning, stage 2: bucket update
  logic              v1_q, v2_q;
  logic [REC_AW-1:0] j1_q, j2_q;
  logic [CHAR_W-1:0] k2_q;
  logic              byp_q;
  logic [REC_AW-1:0] byp_j_q;
  logic [REC_AW-1:0] tail_eff;

  assign tail_raddr = key_rdata;
  assign tail_eff   = byp_q ? byp_j_q : tail_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1_q    <= 1'b0;
      v2_q    <= 1'b0;
      j1_q    <= '0;
      j2_q    <= '0;
      k2_q    <= '0;
      byp_q   <= 1'b0;
      byp_j_q <= '0;
    end else begin
      v1_q    <= issue;
      j1_q    <= issue_rec;
      v2_q    <= v1_q;
      j2_q    <= j1_q;
      k2_q    <= key_rdata;
      // tail of the same bucket is being written this very cycle
      byp_q   <= v1_q && v2_q && (k2_q == key_rdata);
      byp_j_q <= j2_q;
    end
  end

  assign upd       = v2_q;
  assign upd_key   = k2_q;
  assign upd_rec   = j2_q;
  assign dst_we    = v2_q && hit;
  assign dst_waddr = tail_eff;
  assign dst_wdata = j2_q;
  assign pipe_busy = v1_q || v2_q;

  // R5: back-to-back records of one bucket link to their predecessor
  assert_bypass_link_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (v2_q && $past(v2_q) && (k2_q == $past(k2_q)) && hit)
      |-> (dst_we && dst_waddr == $past(j2_q)));
endmodule

// File: rtl/bsp_pass_engine.sv
module bsp_pass_engine
  import bsp_pkg::*;
#(
  parameter int CHAR_W   = 8,
  parameter int REC_AW   = 6,
  parameter int STRIDE_W = 4,
  localparam int KEY_AW  = REC_AW + STRIDE_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ld_valid,
  output logic                ld_ready,
  input  logic                ld_sel,
  input  logic [KEY_AW-1:0]   ld_addr,
  input  logic [CHAR_W-1:0]   ld_data,
  input  logic                start,
  input  logic [REC_AW-1:0]   start_rec,
  input  logic [REC_AW-1:0]   rec_count,
  input  logic [STRIDE_W-1:0] stride,
  output logic                busy,
  output logic                done,
  output logic [REC_AW-1:0]   new_start,
  output logic [REC_AW-1:0]   new_end,
  input  logic [REC_AW-1:0]   rd_addr,
  output logic [REC_AW-1:0]   rd_data
);
  bsp_state_e          state_q;
  logic                first_q;
  logic [REC_AW-1:0]   rem_q, head_rec_q;
  logic [STRIDE_W-1:0] stride_q;
  logic [CHAR_W-1:0]   chain_b_q;
  logic                cv_q, found_q;
  logic [REC_AW-1:0]   prev_tail_q, new_start_q, new_end_q;

  logic                start_acc, ld_fire, issue;
  logic [REC_AW-1:0]   src_rdata, rec_cur;
  logic [KEY_AW-1:0]   key_addr;
  logic [CHAR_W-1:0]   key_rdata;

  logic [CHAR_W-1:0]   s_tail_raddr, t_raddr, upd_key;
  logic [REC_AW-1:0]   t_rdata, upd_rec, c_head;
  logic                upd, hit, c_flag, pipe_busy;
  logic                s_dst_we, chain_we, dst_we;
  logic [REC_AW-1:0]   s_dst_waddr, s_dst_wdata, dst_waddr, dst_wdata;
  logic                in_chain;

  assign busy      = (state_q != ST_IDLE) && (state_q != ST_DONE);
  assign done      = (state_q == ST_DONE);
  assign ld_ready  = !busy;
  assign ld_fire   = ld_valid && ld_ready;
  assign start_acc = start && !busy;
  assign issue     = (state_q == ST_SCAN);
  assign in_chain  = (state_q == ST_CHAIN) || (state_q == ST_CTAIL);
  assign new_start = new_start_q;
  assign new_end   = new_end_q;

  // next record arrives straight from the link memory's output register
  assign rec_cur  = first_q ? head_rec_q : src_rdata;
  assign key_addr = {{STRIDE_W{1'b0}}, rec_cur} * {{REC_AW{1'b0}}, stride_q};

  bsp_ram #(.AW(KEY_AW), .DW(CHAR_W)) u_key (
    .clk(clk), .we(ld_fire && !ld_sel), .waddr(ld_addr), .wdata(ld_data),
    .raddr(key_addr), .rdata(key_rdata)
  );

  bsp_ram #(.AW(REC_AW), .DW(REC_AW)) u_src (
    .clk(clk), .we(ld_fire && ld_sel), .waddr(ld_addr[REC_AW-1:0]),
    .wdata(ld_data[REC_AW-1:0]), .raddr(rec_cur), .rdata(src_rdata)
  );

  bsp_scan #(.CHAR_W(CHAR_W), .REC_AW(REC_AW)) u_scan (
    .clk(clk), .rst_n(rst_n), .issue(issue), .issue_rec(rec_cur),
    .key_rdata(key_rdata), .tail_raddr(s_tail_raddr), .tail_rdata(t_rdata),
    .hit(hit), .upd(upd), .upd_key(upd_key), .upd_rec(upd_rec),
    .dst_we(s_dst_we), .dst_waddr(s_dst_waddr), .dst_wdata(s_dst_wdata),
    .pipe_busy(pipe_busy)
  );

  assign t_raddr = (state_q == ST_CHAIN) ? chain_b_q : s_tail_raddr;

  bsp_buckets #(.CHAR_W(CHAR_W), .REC_AW(REC_AW)) u_bkt (
    .clk(clk), .rst_n(rst_n), .clr(start_acc), .upd(upd), .upd_key(upd_key),
    .upd_rec(upd_rec), .hit(hit), .t_raddr(t_raddr), .t_rdata(t_rdata),
    .c_raddr(chain_b_q), .c_head(c_head), .c_flag(c_flag)
  );

  // join stage: link previous tail to this head, then seal the last tail
  assign chain_we = found_q && ((cv_q && c_flag) ||
                                (state_q == ST_CTAIL && !cv_q));

  always_comb begin
    if (in_chain) begin
      dst_we    = chain_we;
      dst_waddr = prev_tail_q;
      dst_wdata = cv_q ? c_head : '1;
    end else begin
      dst_we    = s_dst_we;
      dst_waddr = s_dst_waddr;
      dst_wdata = s_dst_wdata;
    end
  end

  bsp_ram #(.AW(REC_AW), .DW(REC_AW)) u_dst (
    .clk(clk), .we(dst_we), .waddr(dst_waddr), .wdata(dst_wdata),
    .raddr(rd_addr), .rdata(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      first_q     <= 1'b0;
      rem_q       <= '0;
      head_rec_q  <= '0;
      stride_q    <= '0;
      chain_b_q   <= '0;
      cv_q        <= 1'b0;
      found_q     <= 1'b0;
      prev_tail_q <= '0;
      new_start_q <= '0;
      new_end_q   <= '0;
    end else if (start_acc) begin
      stride_q   <= stride;
      head_rec_q <= start_rec;
      rem_q      <= rec_count;
      first_q    <= 1'b1;
      found_q    <= 1'b0;
      cv_q       <= 1'b0;
      chain_b_q  <= '0;
      if (rec_count == '0) begin
        state_q     <= ST_DONE;
        new_start_q <= '1;
        new_end_q   <= '1;
      end else begin
        state_q <= ST_SCAN;
      end
    end else begin
      cv_q <= (state_q == ST_CHAIN);
      if (cv_q && c_flag) begin
        if (!found_q) new_start_q <= c_head;
        prev_tail_q <= t_rdata;
        found_q     <= 1'b1;
      end
      unique case (state_q)
        ST_SCAN: begin
          first_q <= 1'b0;
          rem_q   <= rem_q - 1'b1;
          if (rem_q == REC_AW'(1)) state_q <= ST_DRAIN;
        end
        ST_DRAIN: begin
          chain_b_q <= '0;
          if (!pipe_busy) state_q <= ST_CHAIN;
        end
        ST_CHAIN: begin
          chain_b_q <= chain_b_q + 1'b1;
          if (chain_b_q == '1) state_q <= ST_CTAIL;
        end
        ST_CTAIL: begin
          if (!cv_q) begin
            new_end_q <= found_q ? prev_tail_q : '1;
            state_q   <= ST_DONE;
          end
        end
        default: ;
      endcase
    end
  end

  // R9: an empty pass finishes at once with an empty list
  assert_empty_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start_acc && rec_count == '0) |=> (done && new_start == '1 && new_end == '1));

  // R10: results stay put while no new pass is taken
  assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(new_start) && $stable(new_end)));

  // R1: a refused load leaves the ready line low for the pass in flight
  assert_no_load_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && busy && state_q != ST_CTAIL) |=> !ld_ready);
endmodule

// File: tb/bsp_pass_engine_tb.sv
`timescale 1ns/1ps
module bsp_pass_engine_tb;
  localparam int CW = 8, RA = 6, SW = 4, KA = RA + SW;
  localparam int ENDM = (1 << RA) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          ld_valid = 0, ld_ready, ld_sel = 0;
  logic [KA-1:0] ld_addr = '0;
  logic [CW-1:0] ld_data = '0;
  logic          start = 0, busy, done;
  logic [RA-1:0] start_rec = '0, rec_count = '0, new_start, new_end, rd_addr = '0, rd_data;
  logic [SW-1:0] stride = '0;

  bsp_pass_engine #(.CHAR_W(CW), .REC_AW(RA), .STRIDE_W(SW)) u_dut (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_sel(ld_sel), .ld_addr(ld_addr), .ld_data(ld_data), .start(start),
    .start_rec(start_rec), .rec_count(rec_count), .stride(stride),
    .busy(busy), .done(done), .new_start(new_start), .new_end(new_end),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  int n_chk = 0, n_fail = 0;
  int ord[$];
  int exp_l[$];
  int keyv[64];

  task automatic chk(bit ok, string req, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // behavioural timing model: a pass of N records takes N+261 edges
  bit m_busy = 0, m_done = 0, mon_en = 0;
  int m_rem = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_rem = 0;
    end else if (start && !m_busy) begin
      if (rec_count == 0) m_done = 1;
      else begin m_busy = 1; m_done = 0; m_rem = int'(rec_count) + 261; end
    end else if (m_busy) begin
      m_rem--;
      if (m_rem == 0) begin m_busy = 0; m_done = 1; end
    end
  end

  always @(negedge clk) begin
    if (rst_n && mon_en) begin
      chk(busy == m_busy, "R8 busy timing", busy, m_busy);
      chk(done == m_done, "R8 done timing", done, m_done);
      chk(ld_ready == !m_busy, "R1 ready", ld_ready, !m_busy);
    end
  end

  task automatic load(bit sel, int addr, int data);
    @(negedge clk);
    ld_valid = 1; ld_sel = sel; ld_addr = KA'(addr); ld_data = CW'(data);
    @(negedge clk);
    ld_valid = 0;
  endtask

  task automatic rd(int a, output int d);
    @(negedge clk);
    rd_addr = RA'(a);
    @(negedge clk);
    d = int'(rd_data);
  endtask

  task automatic pulse_start(int s, int n, int st);
    @(negedge clk);
    start = 1; start_rec = RA'(s); rec_count = RA'(n); stride = SW'(st);
    @(negedge clk);
    start = 0;
  endtask

  task automatic setup(int st);
    for (int i = 0; i < ord.size(); i++) load(0, ord[i] * st, keyv[ord[i]]);
    for (int i = 0; i < ord.size(); i++)
      load(1, ord[i], (i < ord.size() - 1) ? ord[i+1] : 0);
  endtask

  task automatic build_exp();
    exp_l.delete();
    for (int k = 0; k < 256; k++)
      for (int i = 0; i < ord.size(); i++)
        if (keyv[ord[i]] == k) exp_l.push_back(ord[i]);
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
  endtask

  task automatic check_list(string tag);
    int node, nx;
    build_exp();
    chk(int'(new_start) == exp_l[0], {tag, " R3 R6 new_start"}, new_start, exp_l[0]);
    chk(int'(new_end) == exp_l[exp_l.size()-1], {tag, " R7 new_end"},
        new_end, exp_l[exp_l.size()-1]);
    node = int'(new_start);
    for (int i = 0; i < exp_l.size(); i++) begin
      chk(node == exp_l[i], {tag, " R4 R5 R6 R11 order"}, node, exp_l[i]);
      rd(exp_l[i], nx);
      node = nx;
    end
    chk(node == ENDM, {tag, " R7 end marker"}, node, ENDM);
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int kA[20] = '{5, 5, 5, 0, 200, 255, 5, 0, 0, 17, 200, 255, 255, 3, 5, 17, 0, 128, 128, 9};
    int v, s0, e0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(busy == 0 && done == 0, "R8 reset idle", busy, 0);
    chk(ld_ready == 1, "R1 reset ready", ld_ready, 1);
    mon_en = 1;

    // pass A: mixed keys incl. 0 and 255, stride 1, stray start mid-pass
    ord.delete();
    for (int i = 0; i < 20; i++) begin ord.push_back((7 * i + 3) % 64); keyv[ord[i]] = kA[i]; end
    setup(1);
    pulse_start(ord[0], 20, 1);
    repeat (5) @(negedge clk);
    start = 1; rec_count = 0;            // R2: ignored while busy
    @(negedge clk);
    start = 0;
    wait_done();
    check_list("passA");

    // R10: results hold while idle
    s0 = int'(new_start); e0 = int'(new_end);
    repeat (6) @(negedge clk);
    chk(int'(new_start) == s0 && int'(new_end) == e0 && done, "R10 hold", new_start, s0);

    // pass B: long runs of one key (bypass), stride 3
    ord.delete();
    for (int i = 0; i < 30; i++) begin
      ord.push_back((13 * i + 5) % 64);
      keyv[ord[i]] = (i == 29) ? 255 : ((i % 10 == 0) ? 0 : 42);
    end
    setup(3);
    pulse_start(ord[0], 30, 3);
    repeat (60) @(negedge clk);
    load(1, ord[0], ord[5]);              // R1: offered while busy, must be refused
    wait_done();
    check_list("passB");

    // rerun B: same list proves the refused load did not land (R1 ignored)
    pulse_start(ord[0], 30, 3);
    wait_done();
    check_list("passB-rerun R1");

    // empty pass (R9)
    pulse_start(ord[0], 0, 3);
    chk(done == 1, "R9 done at once", done, 1);
    chk(int'(new_start) == ENDM && int'(new_end) == ENDM, "R9 empty list", new_start, ENDM);
    rd(exp_l[0], v);
    chk(v == exp_l[1], "R9 no link written", v, exp_l[1]);
    rd(exp_l[29], v);
    chk(v == ENDM, "R9 marker intact", v, ENDM);

    // single record, stride 2
    ord.delete();
    ord.push_back(9); keyv[9] = 128;
    setup(2);
    pulse_start(9, 1, 2);
    wait_done();
    check_list("single");

    mon_en = 0;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule